// File: doc/BRIEF.md
# DSP Power Mode Controller

This block sequences a DSP core between three operating modes: ACTIVE, IDLE and STOP. In ACTIVE the core clock runs. In IDLE the core clock is gated off and the PLL stays powered, so a wake returns to ACTIVE at once. In STOP the core clock is gated off and the PLL is powered down. A wake from STOP therefore passes through a counted settle interval, so that the PLL can lock before the core clock is enabled again.

The core raises an idle or stop request to enter a low-power mode. The two modes wake on different sources. IDLE wakes on an internal or external interrupt, or on any of the three reset requests: system, soft subsystem and debug interface. STOP wakes on the host CPU continue signal, an external interrupt or any reset request. A STOP exit leaves the core register state untouched, so the core resumes exactly where it stopped.

The length of the settle interval is a cycle count supplied by the integrator. It should be scaled to the master clock: 200 µs at 40 MHz is 8000 cycles, and slower clocks need proportionately fewer cycles.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the outputs read `mode_o`=00 (ACTIVE), `core_clk_en`=1, `pll_pd`=0 and `settle_busy`=0.
- R2: In ACTIVE, at the clock edge that samples it:
  - `stop_req` moves the block to STOP: `mode_o`=10, `core_clk_en`=0, `pll_pd`=1.
  - `idle_req` alone moves it to IDLE: `mode_o`=01, `core_clk_en`=0, `pll_pd`=0.
  - When both requests are high, STOP wins.
- R3: In ACTIVE, a high `sys_rst`, `soft_rst` or `dbg_rst` keeps the block in ACTIVE, even when a sleep request is high in the same cycle.
- R4: In IDLE, `int_req`, `ext_int_req`, `sys_rst`, `soft_rst` or `dbg_rst` returns the block to ACTIVE at the next edge, with `core_clk_en`=1 and `settle_busy`=0.
- R5: `host_continue` is ignored in IDLE, and `int_req` is ignored in STOP. In both cases the block stays in its low-power mode.
- R6: In STOP, `host_continue`, `ext_int_req`, `sys_rst`, `soft_rst` or `dbg_rst` ends STOP at the next edge. The block then reads `mode_o`=00, `pll_pd`=0, `core_clk_en`=0 and `settle_busy`=1.
- R7: `settle_busy` stays high for exactly `settle_cycles` clock cycles, with a value of 0 treated as 1. The count is sampled at the wake edge. After the interval, `core_clk_en`=1 and `settle_busy`=0.
- R8: While `settle_busy` is high, the following have no effect: sleep requests, wake sources and changes to `settle_cycles`.
- R9: `core_clk_en` and `pll_pd` are never high together, and `core_clk_en` is low whenever `settle_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| idle_req | input | 1 | Core request to enter IDLE |
| stop_req | input | 1 | Core request to enter STOP |
| host_continue | input | 1 | Host CPU continue signal (STOP wake) |
| int_req | input | 1 | Internal interrupt request (IDLE wake) |
| ext_int_req | input | 1 | External interrupt request (wakes both modes) |
| sys_rst | input | 1 | System reset request |
| soft_rst | input | 1 | Soft subsystem reset request |
| dbg_rst | input | 1 | Debug-interface reset request |
| settle_cycles | input | CNT_W | PLL settle interval in clock cycles |
| mode_o | output | 2 | Current mode: 00 ACTIVE, 01 IDLE, 10 STOP |
| core_clk_en | output | 1 | Core clock enable |
| pll_pd | output | 1 | PLL power-down |
| settle_busy | output | 1 | High during the PLL settle countdown |

## Verification
The bench sweeps every wake source against each low-power mode, and every settle count from 0 to 5 against every STOP wake source. It looks for four kinds of error:
- A design that confused the two wake sets would leave IDLE on the host continue signal, or leave STOP on an internal interrupt.
- An off-by-one in the countdown would stretch or shorten busy by a cycle, and a zero count would either hang or skip the settle interval.
- A design that listened to requests while settling would fall back into STOP or IDLE, or restart the count, if a new count were loaded mid-settle.
- A design that let a reset lose to a sleep request in the same cycle would enter a low-power mode.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  // encoding seen on mode_o
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_IDLE   = 2'b01,
    PM_STOP   = 2'b10
  } pm_mode_e;

  // internal controller state
  typedef enum logic [1:0] {
    S_RUN    = 2'd0,
    S_DOZE   = 2'd1,
    S_HALT   = 2'd2,
    S_SETTLE = 2'd3
  } pm_state_e;

endpackage

// File: rtl/pwr_wake_decode.sv
module pwr_wake_decode (
  input  logic int_req,
  input  logic ext_int_req,
  input  logic host_continue,
  input  logic sys_rst,
  input  logic soft_rst,
  input  logic dbg_rst,
  output logic any_rst,
  output logic idle_wake,
  output logic stop_wake
);

  always_comb begin
    any_rst   = sys_rst | soft_rst | dbg_rst;
    // IDLE keeps the PLL alive: any interrupt or reset wakes it
    idle_wake = int_req | ext_int_req | any_rst;
    // STOP: host continue, external interrupt or reset only
    stop_wake = host_continue | ext_int_req | any_rst;
  end

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             cnt_en;

  always_comb begin
    // interval of N cycles counts N-1 down to 0; zero behaves as one
    load_val = (settle_cycles == '0) ? '0 : CNT_W'(settle_cycles - 1'b1);
    cnt_en   = load | (run & (cnt_q != '0));
    cnt_d    = load ? load_val : CNT_W'(cnt_q - 1'b1);
    done     = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle_req,
  input  logic      stop_req,
  input  logic      any_rst,
  input  logic      idle_wake,
  input  logic      stop_wake,
  input  logic      settle_done,
  output pm_state_e state,
  output logic      settle_load,
  output logic      settle_run
);

  pm_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    settle_load = 1'b0;
    settle_run  = 1'b0;
    unique case (state_q)
      S_RUN: begin
        if (any_rst)       state_d = S_RUN;   // reset beats sleep
        else if (stop_req) state_d = S_HALT;  // STOP has priority
        else if (idle_req) state_d = S_DOZE;
      end
      S_DOZE: begin
        if (idle_wake) state_d = S_RUN;
      end
      S_HALT: begin
        if (stop_wake) begin
          state_d     = S_SETTLE;
          settle_load = 1'b1;
        end
      end
      S_SETTLE: begin
        settle_run = 1'b1;
        if (settle_done) state_d = S_RUN;
      end
      default: state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_RUN;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             stop_req,
  input  logic             host_continue,
  input  logic             int_req,
  input  logic             ext_int_req,
  input  logic             sys_rst,
  input  logic             soft_rst,
  input  logic             dbg_rst,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic [1:0]       mode_o,
  output logic             core_clk_en,
  output logic             pll_pd,
  output logic             settle_busy
);

  logic      any_rst, idle_wake, stop_wake;
  logic      settle_load, settle_run, settle_done;
  pm_state_e state;

  pwr_wake_decode wake_i (
    .int_req       (int_req),
    .ext_int_req   (ext_int_req),
    .host_continue (host_continue),
    .sys_rst       (sys_rst),
    .soft_rst      (soft_rst),
    .dbg_rst       (dbg_rst),
    .any_rst       (any_rst),
    .idle_wake     (idle_wake),
    .stop_wake     (stop_wake)
  );

  pwr_mode_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req    (idle_req),
    .stop_req    (stop_req),
    .any_rst     (any_rst),
    .idle_wake   (idle_wake),
    .stop_wake   (stop_wake),
    .settle_done (settle_done),
    .state       (state),
    .settle_load (settle_load),
    .settle_run  (settle_run)
  );

  pwr_settle_timer #(.CNT_W(CNT_W)) timer_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (settle_load),
    .run           (settle_run),
    .settle_cycles (settle_cycles),
    .done          (settle_done)
  );

  // settle counts as ACTIVE on mode_o, with the clock still held off
  always_comb begin
    unique case (state)
      S_DOZE:  mode_o = PM_IDLE;
      S_HALT:  mode_o = PM_STOP;
      default: mode_o = PM_ACTIVE;
    endcase
    core_clk_en = (state == S_RUN);
    pll_pd      = (state == S_HALT);
    settle_busy = (state == S_SETTLE);
  end

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_req,
  input logic             stop_req,
  input logic             host_continue,
  input logic             int_req,
  input logic             ext_int_req,
  input logic             sys_rst,
  input logic             soft_rst,
  input logic             dbg_rst,
  input logic [CNT_W-1:0] settle_cycles,
  input logic [1:0]       mode_o,
  input logic             core_clk_en,
  input logic             pll_pd,
  input logic             settle_busy
);

  logic             rst_any;
  logic [CNT_W:0]   len_q;
  logic [CNT_W-1:0] exp_q;

  assign rst_any = sys_rst | soft_rst | dbg_rst;

  // measure each settle window with a counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      exp_q <= '0;
    end else if (mode_o == PM_STOP && (host_continue || ext_int_req || rst_any)) begin
      len_q <= '0;
      exp_q <= (settle_cycles == '0) ? CNT_W'(1) : settle_cycles;
    end else if (settle_busy) begin
      len_q <= len_q + 1'b1;
    end
  end

  // R9
  clk_pd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_clk_en && pll_pd));

  // R9
  busy_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> !core_clk_en);

  // R2
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_ACTIVE && !settle_busy && stop_req && !rst_any) |=> (mode_o == PM_STOP));

  // R3
  rst_holds_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_ACTIVE && !settle_busy && rst_any) |=> (mode_o == PM_ACTIVE && core_clk_en));

  // R5
  idle_ignores_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_IDLE && host_continue && !int_req && !ext_int_req && !rst_any)
      |=> (mode_o == PM_IDLE));

  // R5
  stop_ignores_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_STOP && int_req && !host_continue && !ext_int_req && !rst_any)
      |=> (mode_o == PM_STOP));

  // R6
  stop_wake_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_STOP && ext_int_req) |=> (settle_busy && !pll_pd));

  // R8
  settle_no_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_busy && (stop_req || idle_req)) |=> (mode_o == PM_ACTIVE));

  // R7
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settle_busy) |-> (len_q == {1'b0, exp_q} && core_clk_en));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .idle_req      (idle_req),
  .stop_req      (stop_req),
  .host_continue (host_continue),
  .int_req       (int_req),
  .ext_int_req   (ext_int_req),
  .sys_rst       (sys_rst),
  .soft_rst      (soft_rst),
  .dbg_rst       (dbg_rst),
  .settle_cycles (settle_cycles),
  .mode_o        (mode_o),
  .core_clk_en   (core_clk_en),
  .pll_pd        (pll_pd),
  .settle_busy   (settle_busy)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             idle_req, stop_req, host_continue, int_req, ext_int_req;
  logic             sys_rst, soft_rst, dbg_rst;
  logic [CNT_W-1:0] settle_cycles;
  logic [1:0]       mode_o;
  logic             core_clk_en, pll_pd, settle_busy;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwr_mode_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .stop_req(stop_req),
    .host_continue(host_continue), .int_req(int_req), .ext_int_req(ext_int_req),
    .sys_rst(sys_rst), .soft_rst(soft_rst), .dbg_rst(dbg_rst),
    .settle_cycles(settle_cycles), .mode_o(mode_o), .core_clk_en(core_clk_en),
    .pll_pd(pll_pd), .settle_busy(settle_busy)
  );

  // expected output pattern: {mode, clk_en, pll_pd, busy}
  localparam logic [4:0] EXP_ACT  = 5'b00_1_0_0;
  localparam logic [4:0] EXP_IDLE = 5'b01_0_0_0;
  localparam logic [4:0] EXP_STOP = 5'b10_0_1_0;
  localparam logic [4:0] EXP_SETL = 5'b00_0_0_1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag, input logic [4:0] exp);
    chk(tag, {27'd0, mode_o, core_clk_en, pll_pd, settle_busy}, {27'd0, exp});
  endtask

  task automatic clear_in();
    idle_req = 0; stop_req = 0; host_continue = 0; int_req = 0;
    ext_int_req = 0; sys_rst = 0; soft_rst = 0; dbg_rst = 0;
  endtask

  // inputs change and outputs are sampled 2 ns after a rising edge
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // 0 int, 1 ext, 2 continue, 3 sys, 4 soft, 5 dbg
  task automatic drive_src(input int idx);
    case (idx)
      0: int_req       = 1;
      1: ext_int_req   = 1;
      2: host_continue = 1;
      3: sys_rst       = 1;
      4: soft_rst      = 1;
      default: dbg_rst = 1;
    endcase
  endtask

  task automatic go_idle();
    clear_in(); idle_req = 1; tick(); clear_in();
  endtask

  task automatic go_stop();
    clear_in(); stop_req = 1; tick(); clear_in();
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    settle_cycles = 16'd3;
    rst_n = 0;
    #13;
    chk_outs("R1 during reset", EXP_ACT);
    rst_n = 1;
    tick(); tick();
    chk_outs("R1 after reset", EXP_ACT);

    // R2: idle and stop entry, priority
    go_idle();  chk_outs("R2 idle entry", EXP_IDLE);
    int_req = 1; tick(); clear_in(); chk_outs("R4 idle wake int", EXP_ACT);
    go_stop();  chk_outs("R2 stop entry", EXP_STOP);
    host_continue = 1; tick(); clear_in();
    for (int k = 0; k < 5 && settle_busy; k++) tick();
    chk_outs("R7 back to active", EXP_ACT);
    clear_in(); idle_req = 1; stop_req = 1; tick(); clear_in();
    chk_outs("R2 both requests -> STOP", EXP_STOP);
    ext_int_req = 1; tick(); clear_in();
    for (int k = 0; k < 5 && settle_busy; k++) tick();

    // R3: reset requests beat sleep requests in ACTIVE
    for (int s = 3; s < 6; s++) begin
      clear_in(); drive_src(s); stop_req = 1; idle_req = 1; tick(); clear_in();
      chk_outs($sformatf("R3 reset src %0d holds ACTIVE", s), EXP_ACT);
    end

    // R4 and R5: IDLE wake sweep
    go_idle();
    host_continue = 1; tick(); clear_in();
    chk_outs("R5 continue ignored in IDLE", EXP_IDLE);
    stop_req = 1; tick(); clear_in();
    chk_outs("R5 stop_req ignored in IDLE", EXP_IDLE);
    tick();
    for (int s = 0; s < 6; s++) begin
      if (s == 2) continue;
      if (mode_o != 2'b01) go_idle();
      drive_src(s); tick(); clear_in();
      chk_outs($sformatf("R4 idle wake src %0d", s), EXP_ACT);
    end

    // R5: internal interrupt ignored in STOP
    go_stop();
    int_req = 1; tick(); clear_in();
    chk_outs("R5 int ignored in STOP", EXP_STOP);
    idle_req = 1; tick(); clear_in();
    chk_outs("R5 idle_req ignored in STOP", EXP_STOP);

    // R6, R7, R8: STOP wake sources x settle lengths
    for (int s = 1; s < 6; s++) begin
      for (int n = 0; n < 6; n++) begin
        int cnt;
        int exp_len;
        exp_len = (n == 0) ? 1 : n;
        if (mode_o != 2'b10) go_stop();
        settle_cycles = 16'(n);
        drive_src(s); tick(); clear_in();
        chk_outs($sformatf("R6 stop wake src %0d n=%0d", s, n), EXP_SETL);
        cnt = 1;
        settle_cycles = 16'd7;
        if (exp_len >= 2) begin
          stop_req = 1; idle_req = 1; int_req = 1; host_continue = 1; tick(); clear_in();
          chk_outs($sformatf("R8 requests ignored while settling n=%0d", n), EXP_SETL);
          cnt++;
        end
        while (settle_busy && cnt < 40) begin
          chk(" R9 clk_en low while busy", {31'd0, core_clk_en}, 32'd0);
          tick();
          if (settle_busy) cnt++;
        end
        chk($sformatf("R7 settle length src %0d n=%0d", s, n), cnt, exp_len);
        chk_outs($sformatf("R7 active after settle n=%0d", n), EXP_ACT);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule